// File: doc/BRIEF.md
# Dual-clock ping-pong buffer controller

This block runs one dual-port RAM as a pair of pages that the two sides trade back and forth. A producer in clock domain A fills one page with a block of words. Meanwhile a consumer in clock domain B, typically a DMA engine, bursts the other page out. The top address bit of the RAM selects the page, so the two halves of the memory are the two pages.

Domain A owns a single page-select flop. It inverts that flop once a whole block has been written. The flip is held off while the reader reports that it is busy. That busy report reaches domain A through a synchronizer.

The page-select value crosses into domain B through its own synchronizer. When domain B sees the value change, it pulses a block-ready indication and streams out exactly one block from the page that was just handed over. Two sticky flags report faults:
- a page change that arrives while a burst is still running;
- a write deadline in domain A that expires while a full block is still waiting on the busy reader.

Top module: `pingpong_dc_ctrl`

## Requirements
- R1: After reset, `wr_ready` is 1 and `err_ovr` is 0 in domain A. In domain B, `rd_valid`, `blk_ready` and `err_flip` are 0. The page-select flop starts at 0, so the first block goes into page 0.
- R2: In a cycle where `wr_valid` and `wr_ready` are both 1, the word is stored at the next offset of the current write page. The edge that takes word `BLK_LEN` of a block drives `wr_ready` to 0.
- R3: While `wr_ready` is 0, the page-select flop inverts only at an A edge where the synchronized busy flag is 0. The flip returns `wr_ready` to 1. Page-select 0 means domain A writes page 0 and domain B reads page 1; page-select 1 means the reverse.
- R4: When domain B sees the synchronized page-select change while no burst is running, it drives `blk_ready` high for exactly one B cycle. From the next B cycle on, `rd_valid` is high for `BLK_LEN` consecutive cycles. During those cycles `rd_data` carries the handed-over block, in the order the words were written.
- R5: Domain B holds its busy flag from the start of a burst until its last address is issued. Domain A does not flip while the synchronized flag is set, so a block read out never contains words from a later block.
- R6: `err_flip` becomes 1 if the synchronized page-select changes while a burst is running. It stays 1 until `clr_b` is high at a B edge, or until B reset.
- R7: `err_ovr` becomes 1 if `DEADLINE` A cycles after the last flip, a full block is still waiting on the synchronized busy flag. It stays 1 until `clr_a` is high at an A edge, or until A reset.
- R8: A word offered while `wr_ready` is 0 is dropped. It changes no stored word and is never read out.
- R9: In fault-free operation, each flip produces exactly one burst, marked by exactly one `blk_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Writer-domain clock |
| rst_a_n | input | 1 | Writer-domain asynchronous reset, active low |
| wr_valid | input | 1 | A word is offered on `wr_data` |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | The current page still accepts words |
| clr_a | input | 1 | Clears `err_ovr` |
| err_ovr | output | 1 | Sticky flag: write deadline missed while reader busy |
| clk_b | input | 1 | Reader-domain clock |
| rst_b_n | input | 1 | Reader-domain asynchronous reset, active low |
| rd_data | output | DATA_W | Word read out of the handed-over page |
| rd_valid | output | 1 | `rd_data` holds a word of the current burst |
| blk_ready | output | 1 | One-cycle pulse: a new block is available and its burst starts |
| clr_b | input | 1 | Clears `err_flip` |
| err_flip | output | 1 | Sticky flag: page changed during a burst |

## Verification
Each result in domain A is due one A edge after its cause:
- `wr_ready` falls at the edge that takes the last word;
- `err_ovr` sets at the edge after the deadline count is reached;
- a clear takes effect at the next edge.

Domain B responds to a flip about three B edges later, once the synchronizer has settled. `blk_ready` lasts one cycle, and the first word with `rd_valid` follows one B cycle after it. The bench samples each domain on the falling edge of its own clock. It checks the one-edge results exactly in the next sampled cycle. For anything that crosses a synchronizer, it checks the outcome only after the bursts have drained, because the exact crossing cycle depends on the phase between the two clocks.

// File: rtl/pp_pkg.sv
package pp_pkg;

   // Writer fill state: collecting words, or holding a full block until the flip.
   typedef enum logic {
      WS_FILL = 1'b0,
      WS_HOLD = 1'b1
   } wr_state_e;

   // Width of the in-page word offset; at least one bit.
   function automatic int pp_idx_w(input int blk_len);
      return (blk_len <= 2) ? 1 : $clog2(blk_len);
   endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/pp_dpram.sv
module pp_dpram #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk_w,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clk_r,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk_w) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk_r) begin
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/pp_writer.sv
module pp_writer
   import pp_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int BLK_LEN  = 8,
   parameter int IDX_W    = 3,
   parameter int DEADLINE = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_err,
   input  logic              busy_s,
   output logic              wr_ready,
   output logic              page,
   output logic              hold,
   output logic [IDX_W-1:0]  idx,
   output logic              we,
   output logic [IDX_W:0]    waddr,
   output logic [DATA_W-1:0] wdata,
   output logic              err_ovr
);
   localparam int               DL_W    = $clog2(DEADLINE + 1);
   localparam logic [IDX_W-1:0] LAST    = IDX_W'(BLK_LEN - 1);
   localparam logic [DL_W-1:0]  DL_MAX  = DL_W'(DEADLINE);
   localparam logic [DL_W-1:0]  DL_TRIP = DL_W'(DEADLINE - 1);

   wr_state_e        st_q;
   logic [IDX_W-1:0] idx_q;
   logic             page_q;
   logic [DL_W-1:0]  dl_q;
   logic             err_q;
   logic             accept;
   logic             flip;

   assign accept = wr_valid && (st_q == WS_FILL);
   assign flip   = (st_q == WS_HOLD) && !busy_s;

   // Fill counter, hold state and the page-select flop owned by this domain.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WS_FILL;
         idx_q  <= '0;
         page_q <= 1'b0;
      end else if (accept) begin
         if (idx_q == LAST) begin
            st_q  <= WS_HOLD;
            idx_q <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end else if (flip) begin
         st_q   <= WS_FILL;
         page_q <= ~page_q;
      end
   end

   // Cycles since the last flip, saturating at the deadline.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              dl_q <= '0;
      else if (flip)           dl_q <= '0;
      else if (dl_q != DL_MAX) dl_q <= dl_q + 1'b1;
   end

   // Sticky overrun: deadline reached with a full block blocked by the busy reader.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (clr_err) err_q <= 1'b0;
      else if ((dl_q == DL_TRIP) && (st_q == WS_HOLD) && busy_s)
         err_q <= 1'b1;
   end

   assign wr_ready = (st_q == WS_FILL);
   assign page     = page_q;
   assign hold     = (st_q == WS_HOLD);
   assign idx      = idx_q;
   assign we       = accept;
   assign waddr    = {page_q, idx_q};
   assign wdata    = wr_data;
   assign err_ovr  = err_q;
endmodule

// File: rtl/pp_reader.sv
module pp_reader #(
   parameter int BLK_LEN = 8,
   parameter int IDX_W   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            page_s,
   input  logic            clr_err,
   output logic [IDX_W:0]  raddr,
   output logic            busy,
   output logic            blk_ready,
   output logic            rd_valid,
   output logic            err_flip
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_LEN - 1);

   logic             pg_q;
   logic             busy_q;
   logic             rpage_q;
   logic [IDX_W-1:0] idx_q;
   logic             rdy_q;
   logic             vld_q;
   logic             err_q;
   logic             change;

   assign change = (page_s != pg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q    <= 1'b0;
         busy_q  <= 1'b0;
         rpage_q <= 1'b0;
         idx_q   <= '0;
         rdy_q   <= 1'b0;
         vld_q   <= 1'b0;
      end else begin
         pg_q  <= page_s;
         rdy_q <= 1'b0;
         vld_q <= busy_q;          // RAM output lags its address by one cycle
         if (change && !busy_q) begin
            busy_q  <= 1'b1;
            rpage_q <= ~page_s;    // read the page the writer just left
            idx_q   <= '0;
            rdy_q   <= 1'b1;
         end else if (busy_q) begin
            if (idx_q == LAST) begin
               busy_q <= 1'b0;
               idx_q  <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                err_q <= 1'b0;
      else if (clr_err)          err_q <= 1'b0;
      else if (change && busy_q) err_q <= 1'b1;
   end

   assign raddr     = {rpage_q, idx_q};
   assign busy      = busy_q;
   assign blk_ready = rdy_q;
   assign rd_valid  = vld_q;
   assign err_flip  = err_q;
endmodule

// File: rtl/pingpong_dc_ctrl.sv
module pingpong_dc_ctrl
   import pp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int BLK_LEN     = 8,
   parameter int DEADLINE    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_a,
   input  logic              rst_a_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              clr_a,
   output logic              err_ovr,
   input  logic              clk_b,
   input  logic              rst_b_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              blk_ready,
   input  logic              clr_b,
   output logic              err_flip
);
   localparam int IDX_W  = pp_idx_w(BLK_LEN);
   localparam int ADDR_W = IDX_W + 1;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("pingpong_dc_ctrl: DATA_W must be positive");
   end
   if (BLK_LEN < 2) begin : g_bad_blk_len
      $error("pingpong_dc_ctrl: BLK_LEN must be at least 2");
   end
   if (DEADLINE < 2) begin : g_bad_deadline
      $error("pingpong_dc_ctrl: DEADLINE must be at least 2");
   end

   logic              page_a;
   logic              hold_a;
   logic [IDX_W-1:0]  wr_idx;
   logic              busy_sa;
   logic              we_a;
   logic [ADDR_W-1:0] waddr_a;
   logic [DATA_W-1:0] wdata_a;
   logic              page_sb;
   logic              busy_b;
   logic [ADDR_W-1:0] raddr_b;

   pp_writer #(
      .DATA_W  (DATA_W),
      .BLK_LEN (BLK_LEN),
      .IDX_W   (IDX_W),
      .DEADLINE(DEADLINE)
   ) u_wr (
      .clk     (clk_a),
      .rst_n   (rst_a_n),
      .wr_valid(wr_valid),
      .wr_data (wr_data),
      .clr_err (clr_a),
      .busy_s  (busy_sa),
      .wr_ready(wr_ready),
      .page    (page_a),
      .hold    (hold_a),
      .idx     (wr_idx),
      .we      (we_a),
      .waddr   (waddr_a),
      .wdata   (wdata_a),
      .err_ovr (err_ovr)
   );

   pp_sync #(.STAGES(SYNC_STAGES)) u_page_to_b (
      .clk  (clk_b),
      .rst_n(rst_b_n),
      .d    (page_a),
      .q    (page_sb)
   );

   pp_sync #(.STAGES(SYNC_STAGES)) u_busy_to_a (
      .clk  (clk_a),
      .rst_n(rst_a_n),
      .d    (busy_b),
      .q    (busy_sa)
   );

   pp_reader #(
      .BLK_LEN(BLK_LEN),
      .IDX_W  (IDX_W)
   ) u_rd (
      .clk      (clk_b),
      .rst_n    (rst_b_n),
      .page_s   (page_sb),
      .clr_err  (clr_b),
      .raddr    (raddr_b),
      .busy     (busy_b),
      .blk_ready(blk_ready),
      .rd_valid (rd_valid),
      .err_flip (err_flip)
   );

   pp_dpram #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_mem (
      .clk_w(clk_a),
      .we   (we_a),
      .waddr(waddr_a),
      .wdata(wdata_a),
      .clk_r(clk_b),
      .raddr(raddr_b),
      .rdata(rd_data)
   );
endmodule

// File: rtl/pp_chk.sv
module pp_chk #(
   parameter int BLK_LEN = 8,
   parameter int IDX_W   = 3
) (
   input logic             clk_a,
   input logic             rst_a_n,
   input logic             wr_valid,
   input logic             wr_ready,
   input logic [IDX_W-1:0] wr_idx,
   input logic             page_a,
   input logic             hold_a,
   input logic             busy_sa,
   input logic             clr_a,
   input logic             err_ovr,
   input logic             clk_b,
   input logic             rst_b_n,
   input logic             busy_b,
   input logic             blk_ready,
   input logic             rd_valid,
   input logic             clr_b,
   input logic             err_flip
);
   a_r2_ready_drops_on_last: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (wr_valid && wr_ready && (wr_idx == IDX_W'(BLK_LEN - 1))) |=> !wr_ready);

   a_r3_flip_only_when_idle: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (page_a != $past(page_a)) |-> ($past(hold_a) && !$past(busy_sa)));

   a_r7_ovr_sticky: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (err_ovr && !clr_a) |=> err_ovr);

   a_r7_ovr_clear: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      clr_a |=> !err_ovr);

   a_r4_ready_one_cycle: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      blk_ready |=> (!blk_ready && rd_valid));

   a_r5_ready_marks_busy: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      blk_ready |-> busy_b);

   a_r4_valid_after_ready: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      $rose(rd_valid) |-> $past(blk_ready));

   a_r6_flip_sticky: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (err_flip && !clr_b) |=> err_flip);
endmodule

bind pingpong_dc_ctrl pp_chk #(
   .BLK_LEN(BLK_LEN),
   .IDX_W  (IDX_W)
) u_pp_chk (
   .clk_a    (clk_a),
   .rst_a_n  (rst_a_n),
   .wr_valid (wr_valid),
   .wr_ready (wr_ready),
   .wr_idx   (wr_idx),
   .page_a   (page_a),
   .hold_a   (hold_a),
   .busy_sa  (busy_sa),
   .clr_a    (clr_a),
   .err_ovr  (err_ovr),
   .clk_b    (clk_b),
   .rst_b_n  (rst_b_n),
   .busy_b   (busy_b),
   .blk_ready(blk_ready),
   .rd_valid (rd_valid),
   .clr_b    (clr_b),
   .err_flip (err_flip)
);

// File: tb/pingpong_dc_ctrl_tb_top.sv
module pingpong_dc_ctrl_tb_top;
   localparam int DW    = 16;
   localparam int BLK   = 8;
   localparam int DLINE = 20;

   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic rst_a_n = 1'b0;
   logic rst_b_n = 1'b0;
   logic wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic clr_a = 1'b0;
   logic clr_b = 1'b0;
   logic wr_ready, err_ovr, rd_valid, blk_ready, err_flip;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   int blk_seen = 0;
   int run_len = 0;
   bit want_valid = 1'b0;
   logic [DW-1:0] exp_q[$];

   always #10 clk_a = ~clk_a;   // 50 MHz writer domain
   always #23 clk_b = ~clk_b;   // unrelated reader period

   pingpong_dc_ctrl #(
      .DATA_W(DW), .BLK_LEN(BLK), .DEADLINE(DLINE), .SYNC_STAGES(2)
   ) dut_i (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .clr_a(clr_a), .err_ovr(err_ovr),
      .clk_b(clk_b), .rst_b_n(rst_b_n), .rd_data(rd_data), .rd_valid(rd_valid),
      .blk_ready(blk_ready), .clr_b(clr_b), .err_flip(err_flip)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reader monitor: R4 burst shape and order, R5 no mixing of pages.
   always @(negedge clk_b) begin : mon
      logic [DW-1:0] e;
      if (rst_b_n) begin
         if (want_valid) begin
            chk(rd_valid == 1'b1, "R4 first word one cycle after blk_ready", int'(rd_valid), 1);
            want_valid = 1'b0;
         end
         if (blk_ready) begin
            blk_seen++;
            want_valid = 1'b1;
         end
         if (rd_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 word read with no block pending", int'(rd_data), 0);
            end else begin
               e = exp_q.pop_front();
               chk(rd_data == e, "R5 read word matches written word", int'(rd_data), int'(e));
            end
            run_len++;
         end else if (run_len != 0) begin
            chk(run_len == BLK, "R4 burst length", run_len, BLK);
            run_len = 0;
         end
      end
   end

   task automatic wait_flip(output int held);
      held = 0;
      while (!wr_ready && held < 400) begin
         @(negedge clk_a);
         held++;
      end
      chk(wr_ready == 1'b1, "R3 page flip returns wr_ready", int'(wr_ready), 1);
   endtask

   // Writes one block; fast = back-to-back words. Returns cycles spent held full.
   task automatic write_block(input int pre, input bit fast, output int held);
      repeat (pre) @(negedge clk_a);
      for (int i = 0; i < BLK; i++) begin
         int gap;
         gap = fast ? 0 : int'($urandom_range(2, 0));
         wr_valid = 1'b0;
         repeat (gap) @(negedge clk_a);
         chk(wr_ready == 1'b1, "R2 ready while filling", int'(wr_ready), 1);
         wr_valid = 1'b1;
         wr_data  = DW'($urandom);
         exp_q.push_back(wr_data);
         @(negedge clk_a);
      end
      chk(wr_ready == 1'b0, "R2 ready drops after last word", int'(wr_ready), 0);
      wr_data = 16'hDEAD;   // R8: offered while full, must be dropped
      @(negedge clk_a);
      wr_valid = 1'b0;
      wait_flip(held);
   endtask

   task automatic drain();
      int n;
      n = 0;
      while ((exp_q.size() != 0 || rd_valid || run_len != 0) && n < 400) begin
         @(negedge clk_b);
         n++;
      end
      repeat (4) @(negedge clk_b);
      chk(exp_q.size() == 0, "R4 every written block read out", exp_q.size(), 0);
      @(negedge clk_a);
   endtask

   initial begin : watchdog
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog R3 run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int held;
      int b0;
      int n;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk_a);
      rst_a_n = 1'b1;
      rst_b_n = 1'b1;
      @(negedge clk_a);
      chk(wr_ready == 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);
      chk(err_ovr == 1'b0, "R1 err_ovr after reset", int'(err_ovr), 0);
      @(negedge clk_b);
      chk(rd_valid == 1'b0 && blk_ready == 1'b0, "R1 reader idle after reset",
          int'({rd_valid, blk_ready}), 0);
      chk(err_flip == 1'b0, "R1 err_flip after reset", int'(err_flip), 0);
      @(negedge clk_a);

      // Normal traffic with random gaps (R3, R4, R8, R9).
      for (int k = 0; k < 6; k++) write_block((k == 0) ? 0 : 24, 1'b0, held);
      drain();
      chk(blk_seen == 6, "R9 one burst per flip", blk_seen, 6);
      chk(err_flip == 1'b0, "R6 no flip error in normal traffic", int'(err_flip), 0);
      chk(err_ovr == 1'b0, "R7 no overrun in normal traffic", int'(err_ovr), 0);

      // Deadline fault: next block is full while the reader is still busy.
      write_block(4, 1'b0, held);
      write_block(8, 1'b1, held);
      chk(held >= 3, "R5 flip held off while reader busy", held, 3);
      chk(err_ovr == 1'b1, "R7 overrun flag set", int'(err_ovr), 1);
      repeat (5) @(negedge clk_a);
      chk(err_ovr == 1'b1, "R7 overrun flag sticky", int'(err_ovr), 1);
      clr_a = 1'b1;
      @(negedge clk_a);
      clr_a = 1'b0;
      chk(err_ovr == 1'b0, "R7 overrun cleared by clr_a", int'(err_ovr), 0);
      drain();
      chk(blk_seen == 8, "R9 burst count after overrun", blk_seen, 8);

      // Flip fault: page-select returns to 0 through an A reset mid-burst.
      b0 = blk_seen;
      write_block(4, 1'b0, held);   // ninth flip: page-select now 1, reader on page 0
      n = 0;
      while (blk_seen == b0 && n < 100) begin
         @(negedge clk_b);
         n++;
      end
      @(negedge clk_a);
      rst_a_n = 1'b0;
      repeat (2) @(negedge clk_a);
      rst_a_n = 1'b1;
      @(negedge clk_a);
      chk(wr_ready == 1'b1 && err_ovr == 1'b0, "R1 writer state after A reset",
          int'({wr_ready, err_ovr}), 2);
      drain();
      chk(err_flip == 1'b1, "R6 flip during burst flagged", int'(err_flip), 1);
      repeat (3) @(negedge clk_b);
      chk(err_flip == 1'b1, "R6 flip flag sticky", int'(err_flip), 1);
      clr_b = 1'b1;
      @(negedge clk_b);
      clr_b = 1'b0;
      chk(err_flip == 1'b0, "R6 flip flag cleared by clr_b", int'(err_flip), 0);
      @(negedge clk_a);

      // Recovery traffic after the fault.
      b0 = blk_seen;
      write_block(24, 1'b0, held);
      write_block(24, 1'b0, held);
      drain();
      chk(blk_seen == b0 + 2, "R9 bursts after recovery", blk_seen, b0 + 2);
      chk(err_flip == 1'b0 && err_ovr == 1'b0, "R6 R7 flags quiet after recovery",
          int'({err_flip, err_ovr}), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule